// File: doc/BRIEF.md
# Conversion-Result Byte Link

This block sits between a 12-bit analog-to-digital converter and a host with an 8-bit data path. It watches the converter's status line, which is high while a conversion runs and falls when the result is ready. On that falling edge it latches the 12-bit result and sets a done flag. The host then collects the result as two bytes. The first byte holds the upper eight result bits. The second byte holds the lower four result bits in its upper nibble, with zeros below them.

A static two-bit mode input chooses how the host learns of a result.

- **Polled mode (0):** the done flag appears in a status byte.
- **Interrupt mode (1):** the done flag drives an interrupt line.
- **DMA mode (2):** the done flag drives a DMA request line.

In polled and interrupt modes, the host picks the byte itself by writing a select bit, and clears the flag by writing to a clear address. In DMA mode, the block steps through a two-transfer acknowledge handshake and clears the flag itself.

Mode 3 keeps results but signals nothing. The status line and the acknowledge input are asynchronous and are synchronized inside the block. A second result that arrives before the first has been fully delivered is reported as an overrun.

Top module: `adc_result_link`

## Requirements
- R1: A falling edge on `conv_stat` sets the done flag. The flag is set on the third rising clock edge after the input falls (two synchronizer stages plus the flag register).
- R2: Reading address 1 returns the status byte:
  - bit 7 is the done flag, in mode 0 only;
  - bit 6 is the overrun flag;
  - bits 5:0 read zero.
- R3: `irq` equals the done flag in mode 1 and is 0 in every other mode.
- R4: Reading address 0 returns a data byte chosen by the select bit, which is written through bit 0 of a write to address 2:
  - select 0 gives result bits 11:4;
  - select 1 gives result bits 3:0 in byte bits 7:4, with byte bits 3:0 zero.
- R5: A write to address 3 clears the done flag, the overrun flag and the DMA byte toggle.
- R6: `dreq` equals the done flag in mode 2 and is 0 in every other mode.
- R7: In mode 2, the end of the first acknowledge (falling `dack` while the flag is set and the toggle is 0) sets the toggle. `dreq` stays high, and `dma_rdata` changes from result bits 11:4 to the low byte.
- R8: In mode 2, the end of the second acknowledge returns the toggle to 0 and clears the done flag. This drops `dreq` and leaves `dma_rdata` on the high byte.
- R9: A falling edge on `conv_stat` while the done flag is set, and is not being cleared in that cycle, sets the overrun flag and replaces the stored result.
- R10: The result is latched on the detected falling edge. Later changes on `conv_result` do not alter the bytes read.
- R11: Outside mode 2, `dack` is ignored: the done flag and the data byte stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Delivery mode: 0 polled, 1 interrupt, 2 DMA, 3 silent |
| conv_stat | input | 1 | Converter status; high while converting, falls when the result is ready (asynchronous) |
| conv_result | input | 12 | Converter result bus |
| dack | input | 1 | DMA acknowledge, active high (asynchronous) |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 2 | Host address: 0 data, 1 status, 2 select, 3 clear |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| irq | output | 1 | Interrupt request |
| dreq | output | 1 | DMA request |
| dma_rdata | output | 8 | Byte offered during DMA transfers |

## Verification
The assertions take the following for granted about the inputs:
- `mode` changes only while the done flag is clear.
- `conv_stat` and `dack` hold each level for at least one clock, so the synchronizers cannot miss an edge.
- `conv_result` is stable from the falling status edge until the edge is detected.
- The host never writes the clear address in the same cycle as a detected status edge.

The stimulus keeps within these limits in four ways:
- It drives every input at the falling clock edge.
- It holds the acknowledge for three cycles and waits four cycles after releasing it.
- It changes the result bus only after the flag is visible.
- It switches mode only after a clear write.

// File: rtl/adc_result_link.sv
module adc_result_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        conv_stat,
  input  logic [11:0] conv_result,
  input  logic        dack,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        irq,
  output logic        dreq,
  output logic [7:0]  dma_rdata
);

  localparam int         TOP       = SYNC_STAGES - 1;
  localparam logic [1:0] A_DATA    = 2'd0;
  localparam logic [1:0] A_STAT    = 2'd1;
  localparam logic [1:0] A_SEL     = 2'd2;
  localparam logic [1:0] A_CLR     = 2'd3;
  localparam logic [1:0] M_POLL    = 2'd0;
  localparam logic [1:0] M_IRQ     = 2'd1;
  localparam logic [1:0] M_DMA     = 2'd2;

  logic [SYNC_STAGES-1:0] stat_sync, ack_sync;
  logic stat_prev, ack_prev;
  logic done, ovr, dsel, hsel;
  logic [11:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_sync <= '1;
      ack_sync  <= '0;
      stat_prev <= 1'b1;
      ack_prev  <= 1'b0;
    end else begin
      stat_sync <= {stat_sync[SYNC_STAGES-2:0], conv_stat};
      ack_sync  <= {ack_sync[SYNC_STAGES-2:0], dack};
      stat_prev <= stat_sync[TOP];
      ack_prev  <= ack_sync[TOP];
    end
  end

  wire dma_mode  = (mode == M_DMA);
  wire stat_fall = stat_prev & ~stat_sync[TOP];
  wire ack_end   = ack_prev & ~ack_sync[TOP] & dma_mode & done;
  wire clr_hit   = host_wr & (host_addr == A_CLR);
  wire pair_done = ack_end & dsel;
  wire unused_wdata = &{1'b0, host_wdata[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      ovr   <= 1'b0;
      dsel  <= 1'b0;
      hsel  <= 1'b0;
      res_q <= '0;
    end else begin
      if (host_wr && host_addr == A_SEL)
        hsel <= host_wdata[0];
      if (clr_hit) begin
        done <= 1'b0;
        ovr  <= 1'b0;
        dsel <= 1'b0;
      end else if (ack_end) begin
        dsel <= ~dsel;
        if (dsel)
          done <= 1'b0;
      end
      if (stat_fall) begin
        done  <= 1'b1;
        res_q <= conv_result;
        if (done && !clr_hit && !pair_done)
          ovr <= 1'b1;
      end
    end
  end

  wire [7:0] hi_byte = res_q[11:4];
  wire [7:0] lo_byte = {res_q[3:0], 4'b0000};

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = hsel ? lo_byte : hi_byte;
      A_STAT:  host_rdata = {done & (mode == M_POLL), ovr, 6'b0};
      default: host_rdata = 8'h00;
    endcase
  end

  assign irq       = done & (mode == M_IRQ);
  assign dreq      = done & dma_mode;
  assign dma_rdata = dsel ? lo_byte : hi_byte;

endmodule

// File: rtl/adc_result_link_chk.sv
module adc_result_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       irq,
  input logic       dreq,
  input logic       done,
  input logic       ovr,
  input logic       dsel,
  input logic       stat_fall,
  input logic       clr_hit,
  input logic       ack_end
);

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fall |=> done);

  p_flag_drop_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(clr_hit || ack_end));

  p_irq_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode == 2'd1 && !dreq));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !stat_fall) |=> (!done && !ovr && !dsel));

  p_dreq_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> mode == 2'd2);

  p_first_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && !dsel && !clr_hit) |=> (dsel && done));

  p_second_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && dsel && !clr_hit && !stat_fall) |=> (!dsel && !done));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done && stat_fall));

endmodule

bind adc_result_link adc_result_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .irq(irq), .dreq(dreq),
  .done(done), .ovr(ovr), .dsel(dsel), .stat_fall(stat_fall),
  .clr_hit(clr_hit), .ack_end(ack_end)
);

// File: tb/sim_adc_result_link.sv
module sim_adc_result_link;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic conv_stat = 1'b1, dack = 1'b0, host_wr = 1'b0;
  logic [11:0] conv_result = '0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, dma_rdata;
  logic irq, dreq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_result_link u0 (.*);

  function automatic logic [7:0] hi_of(input int v); return 8'((v >> 4) & 255); endfunction
  function automatic logic [7:0] lo_of(input int v); return 8'((v & 15) << 4); endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic convert(input int v, input bit lat);
    logic [7:0] s;
    @(negedge clk);
    conv_result = 12'(v); conv_stat = 1'b0;
    @(negedge clk); @(negedge clk);
    if (lat) begin rd(2'd1, s); chk("R1 flag not before third edge", s[7], 0); end
    @(negedge clk);
    if (lat) begin rd(2'd1, s); chk("R1 flag at third edge", s[7], 1); end
    conv_result = ~12'(v); conv_stat = 1'b1;
  endtask

  task automatic ack(output logic [7:0] b);
    @(negedge clk);
    dack = 1'b1;
    repeat (3) @(negedge clk);
    b = dma_rdata;
    dack = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] s, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, s); chk("R2 reset status", s, 8'h00);
    rd(2'd0, s); chk("R4 reset data", s, 8'h00);
    chk("R3 reset irq", irq, 0);
    chk("R6 reset dreq", dreq, 0);

    // polled sweep of every result code
    mode = 2'd0;
    for (int v = 0; v < 4096; v++) begin
      convert(v, v < 64);
      rd(2'd1, s); chk("R2 polled status", s, 8'h80);
      rd(2'd0, s); chk("R4 R10 high byte", s, hi_of(v));
      hwrite(2'd2, 8'hFF);
      rd(2'd0, s); chk("R4 low byte", s, lo_of(v));
      hwrite(2'd2, 8'h00);
      hwrite(2'd3, 8'h00);
      rd(2'd1, s); chk("R5 cleared status", s, 8'h00);
    end

    // interrupt mode
    mode = 2'd1;
    for (int i = 0; i < 16; i++) begin
      int v = (i * 397 + 11) % 4096;
      chk("R3 irq idle", irq, 0);
      convert(v, 0);
      chk("R3 irq raised", irq, 1);
      chk("R6 no dreq in irq mode", dreq, 0);
      rd(2'd1, s); chk("R2 bit7 only polled", s, 8'h00);
      hwrite(2'd2, 8'h01);
      rd(2'd0, s); chk("R4 low byte irq mode", s, lo_of(v));
      hwrite(2'd2, 8'h00);
      hwrite(2'd3, 8'h00);
      chk("R5 irq dropped by clear", irq, 0);
    end

    // DMA mode two-transfer handshake
    mode = 2'd2;
    for (int i = 0; i < 32; i++) begin
      int v = (i * 131 + 7) % 4096;
      convert(v, 0);
      chk("R6 dreq raised", dreq, 1);
      chk("R3 no irq in dma", irq, 0);
      chk("R7 first byte offered", dma_rdata, hi_of(v));
      ack(b);
      chk("R7 first transfer byte", b, hi_of(v));
      chk("R7 dreq held", dreq, 1);
      chk("R7 low byte offered", dma_rdata, lo_of(v));
      ack(b);
      chk("R8 second transfer byte", b, lo_of(v));
      chk("R8 dreq dropped", dreq, 0);
      chk("R8 back to high byte", dma_rdata, hi_of(v));
    end

    // overrun, polled
    mode = 2'd0;
    convert(12'h5A3, 1);
    convert(12'hC3E, 0);
    rd(2'd1, s); chk("R9 overrun polled", s, 8'hC0);
    rd(2'd0, s); chk("R9 newer result kept", s, hi_of(12'hC3E));
    hwrite(2'd3, 8'h00);
    rd(2'd1, s); chk("R5 overrun cleared", s, 8'h00);

    // overrun, DMA, between the two transfers
    mode = 2'd2;
    convert(12'h123, 0);
    ack(b);
    chk("R7 toggle before overrun", dma_rdata, lo_of(12'h123));
    convert(12'hABC, 0);
    rd(2'd1, s); chk("R9 overrun dma", s, 8'h40);
    chk("R9 dreq stays", dreq, 1);
    hwrite(2'd3, 8'h00);
    chk("R5 clear drops dreq", dreq, 0);
    chk("R5 clear resets toggle", dma_rdata, hi_of(12'hABC));
    rd(2'd1, s); chk("R5 status after dma clear", s, 8'h00);

    // acknowledge ignored outside DMA
    mode = 2'd0;
    convert(12'h9F1, 0);
    ack(b);
    ack(b);
    rd(2'd1, s); chk("R11 flag kept after dack", s, 8'h80);
    rd(2'd0, s); chk("R11 byte kept after dack", s, hi_of(12'h9F1));
    hwrite(2'd3, 8'h00);

    // silent mode
    mode = 2'd3;
    convert(12'h777, 0);
    chk("R3 no irq in mode 3", irq, 0);
    chk("R6 no dreq in mode 3", dreq, 0);
    rd(2'd1, s); chk("R2 status mode 3", s, 8'h00);
    rd(2'd0, s); chk("R10 data held mode 3", s, hi_of(12'h777));
    hwrite(2'd3, 8'h00);

    summary();
  end
endmodule